// File: doc/BRIEF.md
# Deferred-Store Data Cache Front End

This block sits in the memory stage of a pipeline, in front of a data cache's tag and data arrays. A store uses its memory-stage cycle only for the tag check. When the tag check hits, the store's word address, data and byte enables go into a one-entry pending-write register and are not written to the data array in that cycle. The data array is written with that pending entry later, during the tag-check cycle of the next store that hits. An explicit flush request can also write the pending entry to the array. Because of this, a store hit completes in one cycle instead of two.

A load reads the tag and data arrays in the same cycle. If the load's word matches the pending entry, the bytes that the pending store enabled are replaced with the buffered bytes. Miss handling is limited to a miss flag. Refill and tag writes are done outside the block.

The byte address is split as follows, from the least significant bit upward:
- the byte select: log2(DW/8) bits;
- the word offset within the line: OW bits;
- the set index: IW bits;
- the tag: the remaining upper bits.

The data-array word address is the index placed above the offset, {index, offset}.

Top module: `dcache_store_defer`

## Requirements
- R1: `hit` is 1 in the request's own cycle when `req_valid` is 1, `tag_rd_valid` is 1 and `tag_rd` equals the request tag. `miss` is 1 when `req_valid` is 1 and `hit` is 0. Both flags are 0 when no request is present.
- R2: A store that hits does not put its own data on the data-array write port in its cycle. From the next cycle, its word address, data and byte enables are held as the pending entry.
- R3: When a store hits while an entry is pending, the array write port in that same cycle carries the old pending entry: enable 1, that entry's word address, data and byte enables. The new store replaces the old entry in the buffer, including when both address the same word.
- R4: A store that misses causes no array write and leaves the pending entry unchanged and still pending.
- R5: A load whose tag, index and word offset all equal the pending entry returns the buffered bytes in the byte lanes whose pending byte enable is 1. In the other lanes it returns the data-array bytes. Byte lane b is bits 8b+7..8b.
- R6: A load to a word other than the pending one, such as a different offset in the same line, returns the data-array word unchanged.
- R7: `flush` with no store request present writes the pending entry to the array in that cycle and leaves the buffer empty afterwards. A second flush then writes nothing. When `flush` is raised together with a store request, the store's own rules apply and `flush` has no effect.
- R8: Reset empties the buffer. After reset, a pending store that was never written is lost, and a flush causes no array write.
- R9: A load, or an idle cycle without `flush`, never writes the data array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_addr | input | AW | Byte address |
| req_wdata | input | DW | Store data |
| req_be | input | DW/8 | Store byte enables |
| flush | input | 1 | Write the pending entry to the array if no store is present |
| hit | output | 1 | Tag check hit |
| miss | output | 1 | Tag check miss |
| load_data | output | DW | Load result, with pending bytes merged in |
| tag_idx | output | IW | Tag array read index |
| tag_rd | input | TW | Tag read from the array |
| tag_rd_valid | input | 1 | Valid bit read from the array |
| data_rd_addr | output | IW+OW | Data array read word address |
| data_rd | input | DW | Data array read word |
| data_wr_en | output | 1 | Data array write enable |
| data_wr_addr | output | IW+OW | Data array write word address |
| data_wr_data | output | DW | Data array write word |
| data_wr_be | output | DW/8 | Data array write byte enables |

## Verification
Two events can fall in the same cycle:
- a store hit writing the old pending entry to the array while the buffer captures the new store;
- a load merging pending bytes while a flush writes that same entry to the array.

Both are provoked with back-to-back stores, including a pair that targets the same word with complementary byte enables, and with a load raised together with `flush`. The bench judges the write-port fields against the entry it expects to be leaving the buffer, then reloads the word and compares it with a reference memory that takes every store hit immediately.

// File: rtl/dcache_store_defer.sv
module dcache_store_defer #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int IW = 6,
  parameter int OW = 2,
  localparam int BE  = DW / 8,
  localparam int BW  = $clog2(BE),
  localparam int WAW = IW + OW,
  localparam int TW  = AW - BW - WAW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  input  logic           req_store,
  input  logic [AW-1:0]  req_addr,
  input  logic [DW-1:0]  req_wdata,
  input  logic [BE-1:0]  req_be,
  input  logic           flush,
  output logic           hit,
  output logic           miss,
  output logic [DW-1:0]  load_data,
  output logic [IW-1:0]  tag_idx,
  input  logic [TW-1:0]  tag_rd,
  input  logic           tag_rd_valid,
  output logic [WAW-1:0] data_rd_addr,
  input  logic [DW-1:0]  data_rd,
  output logic           data_wr_en,
  output logic [WAW-1:0] data_wr_addr,
  output logic [DW-1:0]  data_wr_data,
  output logic [BE-1:0]  data_wr_be
);

  logic [WAW-1:0] req_word;
  logic [TW-1:0]  req_tag;
  logic           unused_lsb;

  logic           pend_v;
  logic [TW-1:0]  pend_tag;
  logic [WAW-1:0] pend_word;
  logic [DW-1:0]  pend_data;
  logic [BE-1:0]  pend_be;

  logic st_req, st_hit, match;

  assign req_word   = req_addr[BW +: WAW];
  assign req_tag    = req_addr[AW-1 -: TW];
  assign unused_lsb = ^req_addr[BW-1:0];

  assign tag_idx      = req_word[WAW-1 -: IW];
  assign data_rd_addr = req_word;

  assign hit    = req_valid && tag_rd_valid && (tag_rd == req_tag);
  assign miss   = req_valid && !hit;
  assign st_req = req_valid && req_store;
  assign st_hit = st_req && hit;
  assign match  = pend_v && (pend_tag == req_tag) && (pend_word == req_word);

  for (genvar b = 0; b < BE; b++) begin : g_lane
    assign load_data[8*b +: 8] = (match && pend_be[b]) ? pend_data[8*b +: 8]
                                                         : data_rd[8*b +: 8];
  end

  assign data_wr_en   = pend_v && (st_hit || (flush && !st_req));
  assign data_wr_addr = pend_word;
  assign data_wr_data = pend_data;
  assign data_wr_be   = pend_be;

  always_ff @(posedge clk) begin
    if (!rst_n)          pend_v <= 1'b0;
    else if (st_hit)     pend_v <= 1'b1;
    else if (data_wr_en) pend_v <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (st_hit) begin
      pend_tag  <= req_tag;
      pend_word <= req_word;
      pend_data <= req_wdata;
      pend_be   <= req_be;
    end
  end

endmodule

// File: rtl/dcache_store_defer_chk.sv
module dcache_store_defer_chk #(
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int BW  = 2,
  parameter int WAW = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           req_valid,
  input logic           req_store,
  input logic [AW-1:0]  req_addr,
  input logic [DW-1:0]  req_wdata,
  input logic           flush,
  input logic           hit,
  input logic           data_wr_en,
  input logic           pend_v,
  input logic [WAW-1:0] pend_word,
  input logic [DW-1:0]  pend_data
);

  a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_store && hit) |=>
      (pend_v && pend_word == $past(req_addr[BW +: WAW]) && pend_data == $past(req_wdata)));

  a_r4_miss_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_store && !hit) |=>
      (pend_v == $past(pend_v) && pend_data == $past(pend_data) && pend_word == $past(pend_word)));

  a_r7_flush_writes: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !(req_valid && req_store) && pend_v) |-> data_wr_en);

  a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !(req_valid && req_store) && pend_v) |=> !pend_v);

  a_r9_load_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!(req_valid && req_store) && !flush) |-> !data_wr_en);

endmodule

bind dcache_store_defer dcache_store_defer_chk #(
  .AW(AW), .DW(DW), .BW(BW), .WAW(WAW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
  .req_addr(req_addr), .req_wdata(req_wdata), .flush(flush), .hit(hit),
  .data_wr_en(data_wr_en), .pend_v(pend_v), .pend_word(pend_word),
  .pend_data(pend_data)
);

// File: tb/tb_dcache_store_defer.sv
`timescale 1ns/1ps
module tb_dcache_store_defer;
  localparam int TW = 22;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_store = 1'b0, flush = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic [3:0]  req_be = '0;
  logic hit, miss, tag_rd_valid, data_wr_en;
  logic [31:0] load_data, data_rd, data_wr_data;
  logic [5:0]  tag_idx;
  logic [TW-1:0] tag_rd;
  logic [7:0]  data_rd_addr, data_wr_addr;
  logic [3:0]  data_wr_be;

  logic [TW-1:0] tmem [64];
  logic          tv   [64];
  logic [31:0]   dmem [256];
  logic [31:0]   arch [256];

  int n_run = 0, n_fail = 0;
  bit done = 0;
  bit pv = 0;
  logic [7:0] p_w; logic [31:0] p_d; logic [3:0] p_b;

  always #2.5 clk = ~clk;

  assign tag_rd       = tmem[tag_idx];
  assign tag_rd_valid = tv[tag_idx];
  assign data_rd      = dmem[data_rd_addr];

  dcache_store_defer dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be), .flush(flush),
    .hit(hit), .miss(miss), .load_data(load_data), .tag_idx(tag_idx),
    .tag_rd(tag_rd), .tag_rd_valid(tag_rd_valid), .data_rd_addr(data_rd_addr),
    .data_rd(data_rd), .data_wr_en(data_wr_en), .data_wr_addr(data_wr_addr),
    .data_wr_data(data_wr_data), .data_wr_be(data_wr_be)
  );

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw,
                                        input logic [3:0] be);
    logic [31:0] r = old;
    for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = nw[8*b +: 8];
    return r;
  endfunction

  function automatic logic [31:0] init_word(input int i);
    return {16'hC0DE, 8'h00, i[7:0]};
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic do_op(input bit v, input bit s, input bit fl, input int tg, input int ix,
                       input int of, input logic [31:0] wd, input logic [3:0] be,
                       input bit eh, input string rq);
    logic [7:0] w;
    bit st, ew, wen;
    logic [7:0] wa; logic [31:0] wdat; logic [3:0] wbe;
    w = {ix[5:0], of[1:0]};
    @(negedge clk);
    req_valid = v; req_store = s; flush = fl;
    req_addr  = {tg[TW-1:0], ix[5:0], of[1:0], 2'b00};
    req_wdata = wd; req_be = be;
    #1;
    st = v && s;
    chk(hit == (v && eh), "R1", "hit", 32'(hit), 32'(v && eh));
    chk(miss == (v && !eh), "R1", "miss", 32'(miss), 32'(v && !eh));
    if (v && !s && eh) chk(load_data == arch[w], rq, "load_data", load_data, arch[w]);
    ew = (st && eh) ? pv : (!st && fl) ? pv : 1'b0;
    chk(data_wr_en == ew, st ? (eh ? "R3" : "R4") : (fl ? "R7" : "R9"), "data_wr_en",
        32'(data_wr_en), 32'(ew));
    if (ew && data_wr_en) begin
      chk(data_wr_addr == p_w, "R3", "data_wr_addr", 32'(data_wr_addr), 32'(p_w));
      chk(data_wr_data == p_d, "R3", "data_wr_data", data_wr_data, p_d);
      chk(data_wr_be == p_b, "R3", "data_wr_be", 32'(data_wr_be), 32'(p_b));
    end
    wen = data_wr_en; wa = data_wr_addr; wdat = data_wr_data; wbe = data_wr_be;
    @(posedge clk);
    if (wen) dmem[wa] = merge(dmem[wa], wdat, wbe);
    if (st && eh) begin
      pv = 1; p_w = w; p_d = wd; p_b = be;
      arch[w] = merge(arch[w], wd, be);
    end else if (ew) pv = 0;
  endtask

  typedef struct packed {
    logic s; logic fl; logic [7:0] tg; logic [5:0] ix; logic [1:0] of;
    logic [31:0] wd; logic [3:0] be; logic eh; logic [3:0] rid;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 1'b0, 8'd5,  6'd5,  2'd0, 32'h0,        4'h0, 1'b1, 4'd1},
    '{1'b1, 1'b0, 8'd5,  6'd5,  2'd1, 32'h1111_1111, 4'hF, 1'b1, 4'd2},
    '{1'b0, 1'b0, 8'd5,  6'd5,  2'd1, 32'h0,        4'h0, 1'b1, 4'd5},
    '{1'b1, 1'b0, 8'd6,  6'd6,  2'd0, 32'h2222_2222, 4'h3, 1'b1, 4'd3},
    '{1'b0, 1'b0, 8'd5,  6'd5,  2'd1, 32'h0,        4'h0, 1'b1, 4'd3},
    '{1'b0, 1'b0, 8'd6,  6'd6,  2'd0, 32'h0,        4'h0, 1'b1, 4'd5},
    '{1'b1, 1'b0, 8'd9,  6'd7,  2'd0, 32'h4444_4444, 4'hF, 1'b0, 4'd4},
    '{1'b0, 1'b0, 8'd6,  6'd6,  2'd0, 32'h0,        4'h0, 1'b1, 4'd4},
    '{1'b0, 1'b0, 8'd7,  6'd6,  2'd0, 32'h0,        4'h0, 1'b0, 4'd1},
    '{1'b1, 1'b0, 8'd50, 6'd50, 2'd0, 32'h5555_5555, 4'hF, 1'b0, 4'd4},
    '{1'b0, 1'b0, 8'd6,  6'd6,  2'd1, 32'h0,        4'h0, 1'b1, 4'd6},
    '{1'b1, 1'b1, 8'd6,  6'd6,  2'd0, 32'h3333_3333, 4'hC, 1'b1, 4'd7},
    '{1'b0, 1'b0, 8'd6,  6'd6,  2'd0, 32'h0,        4'h0, 1'b1, 4'd5},
    '{1'b0, 1'b1, 8'd6,  6'd6,  2'd0, 32'h0,        4'h0, 1'b1, 4'd7},
    '{1'b0, 1'b0, 8'd6,  6'd6,  2'd0, 32'h0,        4'h0, 1'b1, 4'd7},
    '{1'b0, 1'b1, 8'd6,  6'd6,  2'd0, 32'h0,        4'h0, 1'b1, 4'd7},
    '{1'b0, 1'b0, 8'd6,  6'd6,  2'd2, 32'h0,        4'h0, 1'b1, 4'd6}
  };

  function automatic string lab(input logic [3:0] r);
    case (r)
      4'd1: return "R1";
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      default: return "R7";
    endcase
  endfunction

  initial begin
    for (int i = 0; i < 64; i++) begin tmem[i] = TW'(i); tv[i] = (i < 48); end
    for (int i = 0; i < 256; i++) begin dmem[i] = init_word(i); arch[i] = init_word(i); end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R8: empty buffer after reset, flush writes nothing
    do_op(0, 0, 1, 0, 0, 0, 32'h0, 4'h0, 0, "R8");
    do_op(0, 0, 0, 0, 0, 0, 32'h0, 4'h0, 0, "R9");

    for (int k = 0; k < NV; k++)
      do_op(1, TBL[k].s, TBL[k].fl, int'(TBL[k].tg), int'(TBL[k].ix), int'(TBL[k].of),
            TBL[k].wd, TBL[k].be, TBL[k].eh, lab(TBL[k].rid));

    // R8: pending store lost on reset
    do_op(1, 1, 0, 10, 10, 2, 32'hDEAD_BEEF, 4'hF, 1, "R2");
    @(negedge clk); req_valid = 0; flush = 0; rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    pv = 0; arch[{6'd10, 2'd2}] = init_word({6'd10, 2'd2});
    do_op(1, 0, 0, 10, 10, 2, 32'h0, 4'h0, 1, "R8");
    do_op(0, 0, 1, 0, 0, 0, 32'h0, 4'h0, 0, "R8");

    // back-to-back store hits to the same word, complementary lanes
    do_op(1, 1, 0, 12, 12, 3, 32'hAAAA_AAAA, 4'h5, 1, "R2");
    do_op(1, 1, 0, 12, 12, 3, 32'hBBBB_BBBB, 4'hA, 1, "R3");
    do_op(1, 0, 0, 12, 12, 3, 32'h0, 4'h0, 1, "R5");
    do_op(1, 0, 1, 12, 12, 3, 32'h0, 4'h0, 1, "R7");
    do_op(1, 0, 0, 12, 12, 3, 32'h0, 4'h0, 1, "R7");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule